// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures how fast an external digital signal toggles. It counts the signal's rising edges inside a gate window of fixed length. A gate generator advances on a slow time-base tick from outside the block. It holds the gate high for a programmed number of ticks, then low for the rest of a programmed cycle length. With a 5 kHz tick, a high time of 5000 ticks and a cycle of 10000 ticks, the gate is open for exactly one second, so the result reads directly in hertz.

The block has a down counter that starts from all ones. Each rising edge seen while the gate is open decrements it. When the gate closes, the block subtracts the remaining value from all ones to get the edge count. It then presents that count with a one-cycle valid strobe and reloads the counter at once, ready for the next open window. The edges that arrive while the gate is closed are thrown away. To get a result sooner, shorten the cycle length and keep the high time, so that only the closed phase gets shorter.

An interrupt flag latches with every new result and stays set until software clears it. A sticky flag records any window in which the counter wrapped below zero. The count carries a quantisation error of one edge, so a 10 Hz signal measured over one second is accurate to about ten percent.

Top module: `freq_gate_counter`

## Requirements
- R1: The counter is CNT_W bits wide (default 24) and is loaded with all ones before each window. `result_o` equals all ones minus the counter value left when the gate closes, which is the number of counted edges modulo 2^CNT_W.
- R2: `sig_i` passes through a two-flop synchroniser. Only its rising edges are counted. A level held high for a whole window counts once, and falling edges never count.
- R3: Edges are counted only while `gate_o` is 1. Edges that arrive while the gate is 0 do not change the next window's result.
- R4: Each cycle of `tick_i` pulses keeps `gate_o` at 1 for `cfg_high_i` ticks, then at 0 for `cfg_period_i` − `cfg_high_i` ticks. `gate_o` changes only on clock edges where `tick_i` is 1. `cfg_high_i` must be below `cfg_period_i`.
- R5: `cfg_high_i` and `cfg_period_i` are sampled during reset and at the tick that starts each new gate cycle. A change made mid-cycle takes effect only in the next cycle.
- R6: `result_valid_o` pulses for exactly one clock, on the clock after `gate_o` falls. `result_o` keeps its value in every cycle without that pulse.
- R7: `irq_o` is set together with `result_valid_o` and stays at 1 until `irq_clr_i` is 1. If a clear arrives on the same edge as a new result, the set wins.
- R8: If the counter wraps from zero within a window, `overflow_o` becomes 1 and stays at 1 until reset. The result is still the edge count modulo 2^CNT_W.
- R9: The counter is reloaded when each result is captured, so consecutive windows are independent of one another.
- R10: While `rst` is high, `result_o` is 0 and `result_valid_o`, `irq_o` and `overflow_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick, one clock wide |
| sig_i | input | 1 | Asynchronous signal under measurement |
| cfg_high_i | input | TICK_W | Gate open time in ticks |
| cfg_period_i | input | TICK_W | Full gate cycle in ticks |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| gate_o | output | 1 | Current gate level |
| result_o | output | CNT_W | Edge count from the last window |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| irq_o | output | 1 | Latched result interrupt |
| overflow_o | output | 1 | Sticky counter wrap flag |

## Verification
The bench times the open and closed gate phases at two tick rates. It changes the configuration partway through a cycle; a design that latched the values at once would cut the current window short. It holds the input high for a whole window, which a level-sensitive counter would count as many edges. It also feeds edges during the closed phase, where a design without the gate would carry counts into the next result. Other cases are a clear issued on the same edge as a new capture, which a clear-priority flag would lose, and a window with more edges than the counter can hold. In that last case the result must wrap and the overflow flag must stay set through later clean windows.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;

    localparam int unsigned CNT_W_DEF  = 24;
    localparam int unsigned TICK_W_DEF = 16;
    localparam int unsigned SYNC_DEF   = 2;

    typedef enum logic {
        PH_SHUT = 1'b0,
        PH_OPEN = 1'b1
    } gate_phase_e;

    typedef struct packed {
        logic level;
        logic closed;
    } gate_evt_t;

endpackage

// File: rtl/fgc_gate_gen.sv
`timescale 1ns/1ps
module fgc_gate_gen
    import fgc_pkg::*;
#(
    parameter int unsigned TICK_W = TICK_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [TICK_W-1:0] cfg_high_i,
    input  logic [TICK_W-1:0] cfg_period_i,
    output gate_evt_t         evt_o
);

    logic [TICK_W-1:0] pos_q;
    logic [TICK_W-1:0] high_q;
    logic [TICK_W-1:0] span_q;
    gate_phase_e       phase_q;
    logic              open_d_q;

    logic [TICK_W:0] pos_inc;
    logic            cycle_end;

    assign pos_inc   = {1'b0, pos_q} + {{TICK_W{1'b0}}, 1'b1};
    assign cycle_end = (pos_inc >= {1'b0, span_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            high_q   <= cfg_high_i;
            span_q   <= cfg_period_i;
            phase_q  <= (cfg_high_i != '0) ? PH_OPEN : PH_SHUT;
            open_d_q <= 1'b0;
        end else begin
            open_d_q <= (phase_q == PH_OPEN);
            if (tick_i) begin
                if (cycle_end) begin
                    pos_q   <= '0;
                    high_q  <= cfg_high_i;
                    span_q  <= cfg_period_i;
                    phase_q <= (cfg_high_i != '0) ? PH_OPEN : PH_SHUT;
                end else begin
                    pos_q <= pos_inc[TICK_W-1:0];
                    if (pos_inc == {1'b0, high_q}) begin
                        phase_q <= PH_SHUT;
                    end
                end
            end
        end
    end

    assign evt_o.level  = (phase_q == PH_OPEN);
    assign evt_o.closed = open_d_q & (phase_q == PH_SHUT);

endmodule

// File: rtl/fgc_edge_sync.sv
`timescale 1ns/1ps
module fgc_edge_sync
    import fgc_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], sig_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/fgc_capture.sv
`timescale 1ns/1ps
module fgc_capture
    import fgc_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  gate_evt_t        evt_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] result_o,
    output logic             valid_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] PRELOAD = '1;

    logic [CNT_W-1:0] down_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            down_q   <= PRELOAD;
            result_o <= '0;
            valid_o  <= 1'b0;
            wrap_o   <= 1'b0;
        end else begin
            valid_o <= evt_i.closed;
            wrap_o  <= 1'b0;
            if (evt_i.closed) begin
                result_o <= PRELOAD - down_q;
                down_q   <= PRELOAD;
            end else if (evt_i.level && rise_i) begin
                down_q <= down_q - {{(CNT_W-1){1'b0}}, 1'b1};
                wrap_o <= (down_q == '0);
            end
        end
    end

endmodule

// File: rtl/freq_gate_counter.sv
`timescale 1ns/1ps
module freq_gate_counter
    import fgc_pkg::*;
#(
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned TICK_W = TICK_W_DEF,
    parameter int unsigned SYNC_N = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              sig_i,
    input  logic [TICK_W-1:0] cfg_high_i,
    input  logic [TICK_W-1:0] cfg_period_i,
    input  logic              irq_clr_i,
    output logic              gate_o,
    output logic [CNT_W-1:0]  result_o,
    output logic              result_valid_o,
    output logic              irq_o,
    output logic              overflow_o
);

    gate_evt_t evt;
    logic      rise;
    logic      wrap;
    logic      irq_q;
    logic      ovf_q;

    fgc_gate_gen #(.TICK_W(TICK_W)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .cfg_high_i   (cfg_high_i),
        .cfg_period_i (cfg_period_i),
        .evt_o        (evt)
    );

    fgc_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (sig_i),
        .rise_o (rise)
    );

    fgc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .rise_i   (rise),
        .result_o (result_o),
        .valid_o  (result_valid_o),
        .wrap_o   (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            irq_q <= evt.closed | (irq_q & ~irq_clr_i);
            ovf_q <= ovf_q | wrap;
        end
    end

    assign gate_o     = evt.level;
    assign irq_o      = irq_q;
    assign overflow_o = ovf_q;

endmodule

// File: rtl/fgc_checker.sv
`timescale 1ns/1ps
module fgc_checker #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             gate_o,
    input logic [CNT_W-1:0] result_o,
    input logic             result_valid_o,
    input logic             irq_o,
    input logic             irq_clr_i,
    input logic             overflow_o
);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o);

    // R6
    valid_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o) |=> result_valid_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid_o |-> $stable(result_o));

    // R7
    irq_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> irq_o);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

endmodule

bind freq_gate_counter fgc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .gate_o         (gate_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o),
    .irq_o          (irq_o),
    .irq_clr_i      (irq_clr_i),
    .overflow_o     (overflow_o)
);

// File: tb/freq_gate_counter_tb.sv
`timescale 1ns/1ps
module freq_gate_counter_tb;

    localparam int unsigned CNT_W  = 10;
    localparam int unsigned TICK_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic              sig_i = 1'b0;
    logic [TICK_W-1:0] cfg_high_i = 16'd40;
    logic [TICK_W-1:0] cfg_period_i = 16'd80;
    logic              irq_clr_i = 1'b0;
    logic              gate_o;
    logic [CNT_W-1:0]  result_o;
    logic              result_valid_o;
    logic              irq_o;
    logic              overflow_o;

    int errors = 0;
    int checks = 0;
    int tick_div = 1;
    bit done = 0;

    freq_gate_counter #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick_i),
        .sig_i          (sig_i),
        .cfg_high_i     (cfg_high_i),
        .cfg_period_i   (cfg_period_i),
        .irq_clr_i      (irq_clr_i),
        .gate_o         (gate_o),
        .result_o       (result_o),
        .result_valid_o (result_valid_o),
        .irq_o          (irq_o),
        .overflow_o     (overflow_o)
    );

    always #10 clk = ~clk;

    initial begin
        int divc = 0;
        forever begin
            @(negedge clk);
            if (tick_div <= 1) begin
                tick_i = 1'b1;
            end else begin
                divc++;
                tick_i = (divc >= tick_div);
                if (tick_i) divc = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic longint expect_count(input int n);
        return longint'(n % (1 << CNT_W));
    endfunction

    task automatic wait_rise();
        while (gate_o !== 1'b0) @(negedge clk);
        while (gate_o !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(input logic lvl, output int cyc);
        cyc = 0;
        while (gate_o === lvl) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_edges(input int n);
        for (int i = 0; i < n; i++) begin
            sig_i = 1'b1;
            repeat (2) @(negedge clk);
            sig_i = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic run_window(input int n, input int m, input bit clr_on_close,
                              input bit hold, input string tag);
        longint exp;
        wait_rise();
        repeat (6) @(negedge clk);
        if (hold) sig_i = 1'b1;
        else pulse_edges(n);
        while (gate_o === 1'b1) @(negedge clk);
        if (clr_on_close) irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        exp = hold ? 1 : expect_count(n);
        check(result_valid_o === 1'b1, "R6 valid after close", result_valid_o, 1);
        check(result_o === exp[CNT_W-1:0], tag, result_o, exp);
        check(irq_o === 1'b1, "R7 irq set with result", irq_o, 1);
        @(negedge clk);
        check(result_valid_o === 1'b0, "R6 valid one cycle", result_valid_o, 0);
        sig_i = 1'b0;
        pulse_edges(m);
    endtask

    initial begin
        int hc;
        int lc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(result_o === '0, "R10 result in reset", result_o, 0);
        check(result_valid_o === 1'b0, "R10 valid in reset", result_valid_o, 0);
        check(irq_o === 1'b0, "R10 irq in reset", irq_o, 0);
        check(overflow_o === 1'b0, "R10 overflow in reset", overflow_o, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R4 phase lengths, tick every clock
        wait_rise();
        measure(1'b1, hc);
        check(hc == 40, "R4 open time div1", hc, 40);
        measure(1'b0, lc);
        check(lc == 40, "R4 closed time div1", lc, 40);

        // R4 phase lengths, tick every third clock
        tick_div = 3;
        wait_rise();
        measure(1'b1, hc);
        check(hc == 120, "R4 open time div3", hc, 120);
        measure(1'b0, lc);
        check(lc == 120, "R4 closed time div3", lc, 120);
        tick_div = 1;

        // R5 mid-cycle config change applies next cycle
        wait_rise();
        cfg_high_i = 16'd25;
        cfg_period_i = 16'd60;
        measure(1'b1, hc);
        check(hc == 40, "R5 current open unchanged", hc, 40);
        measure(1'b0, lc);
        check(lc == 40, "R5 current closed unchanged", lc, 40);
        cfg_high_i = 16'd200;
        cfg_period_i = 16'd300;
        measure(1'b1, hc);
        check(hc == 25, "R5 next open uses new", hc, 25);
        measure(1'b0, lc);
        check(lc == 35, "R5 next closed uses new", lc, 35);

        // R2 a held level counts once
        run_window(0, 0, 1'b0, 1'b1, "R2 held level counts once");
        check(irq_o === 1'b1, "R7 irq still set", irq_o, 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        check(irq_o === 1'b0, "R7 irq cleared", irq_o, 0);

        run_window(5, 3, 1'b0, 1'b0, "R1 five edges");
        repeat (20) @(negedge clk);
        check(irq_o === 1'b1, "R7 irq holds without clear", irq_o, 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        check(irq_o === 1'b0, "R7 irq cleared again", irq_o, 0);

        // R3 closed-phase edges leave zero count
        run_window(0, 15, 1'b0, 1'b0, "R3 zero after closed edges");
        run_window(2, 0, 1'b0, 1'b0, "R3 closed edges not carried");
        // R7 set wins over simultaneous clear
        run_window(7, 4, 1'b1, 1'b0, "R7 set beats clear count");

        // R9 R1 random independent windows
        for (int w = 0; w < 8; w++) begin
            int n = $urandom_range(0, 45);
            int m = $urandom_range(0, 15);
            run_window(n, m, 1'b0, 1'b0, "R9 random window");
        end

        // R8 counter wrap
        check(overflow_o === 1'b0, "R8 no overflow yet", overflow_o, 0);
        cfg_high_i = 16'd5000;
        cfg_period_i = 16'd5200;
        run_window(1030, 0, 1'b0, 1'b0, "R8 wrapped count");
        check(overflow_o === 1'b1, "R8 overflow set", overflow_o, 1);
        run_window(3, 0, 1'b0, 1'b0, "R8 clean window after wrap");
        check(overflow_o === 1'b1, "R8 overflow sticky", overflow_o, 1);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

endmodule